// File: doc/BRIEF.md
# Padded Vertex Count Generator

This block turns an unsigned 32-bit vertex count into a padded count that a thread dispatcher can split into vertex and instance indices cheaply. Every padded value is an odd factor (1, 3, 5, 7 or 9) times a power of two. It is always a multiple of four and always strictly larger than the count it came from. Along with the padded value, the block reports the exponent and an odd-factor code. Attribute addressing uses these two to take a modulus by the padded count.

The block is a single registered stage. When `in_valid` is sampled high, the result appears on the next clock edge with `out_valid` high. While no new request arrives, the outputs hold their last value. For counts of 64 and above, the result comes from the most significant set bit and the three bits below it. For smaller counts, the block picks the smallest allowed value that qualifies. If a result would not fit in 32 bits, an overflow flag is raised.

Top module: `vtx_pad_gen`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is sampled high, and low otherwise. While `in_valid` is low, the data outputs keep their previous values.
- R2: When no overflow is flagged, `out_padded` is strictly greater than the count that produced it, even when that count already has an allowed form.
- R3: When no overflow is flagged, `out_padded` is a multiple of four and equals (2·`out_odd` + 1)·2^`out_shift`, with `out_odd` in 0..4 (0→1, 1→3, 2→5, 3→7, 4→9).
- R4: For a count of 64 or more, let n be the bit position of the leading one minus 3, and look at the leading one plus the next three bits. Pattern 1000 gives 9·2^n. Pattern 1001 gives 5·2^(n+1). Patterns 1010 and 1011 give 3·2^(n+2). Patterns 1100 and 1101 give 7·2^(n+1). Patterns 1110 and 1111 give 2^(n+4).
- R5: A count below 64 gives the smallest value of the form {1,3,5,7,9}·2^k that is a multiple of four and greater than the count. Counts 0, 1, 2 and 3 give 4; 4–7 give 8; 8–11 give 12; 12–15 give 16; 16–19 give 20.
- R6: When the result would be 2^32 or more (a count of 0xE0000000 or above), `out_overflow` is 1, `out_padded` is 0, `out_shift` is 32 and `out_odd` is 0. Otherwise `out_overflow` is 0.
- R7: A count of 70 gives a padded value of 72, with `out_odd` = 4 and `out_shift` = 3.
- R8: A synchronous active-low reset clears `out_valid`, `out_padded`, `out_shift`, `out_odd` and `out_overflow` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for `in_count` |
| in_count | input | 32 | Unsigned vertex count |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_padded | output | 32 | Padded count |
| out_shift | output | 6 | Power-of-two exponent of the padded count |
| out_odd | output | 3 | Odd-factor code, factor = 2·code + 1 |
| out_overflow | output | 1 | Padded count does not fit in 32 bits |

## Verification
The hardest cases to reach are the ones where the leading-bit rule lands in the top bit position. There, 9, 5, 3 and 7 times a power of two still fit in 32 bits, but the 111x pattern reaches 2^32. The vector table therefore includes 0x80000000, 0xDFFFFFFF, 0xE0000000 and 0xFFFFFFFF, so that the last result that fits and the first one that overflows sit on either side of that boundary. It also covers the seam between the small-count search and the leading-bit rule at 63/64/70, and each of the five leading-bit patterns at several magnitudes.

// File: rtl/vtx_pad_pkg.sv
// Package: shared widths and the odd-factor code for the padded count generator.
// Assumes counts are unsigned; the odd code values are consumed downstream,
// so their numeric values (factor = 2*code + 1) are fixed.
package vtx_pad_pkg;
    localparam int CNT_W      = 32;                  // vertex count width
    localparam int SHIFT_W    = $clog2(CNT_W + 1);   // holds exponents 0..CNT_W
    localparam int ODD_W      = 3;                   // odd-factor code width
    localparam int SMALL_LIM  = 64;                  // below this: search path
    localparam int MIN_SHIFT  = 2;                   // result is a multiple of four
    localparam int WIDE_W     = CNT_W + 4;           // room for 9 << CNT_W

    typedef enum logic [ODD_W-1:0] {
        ODD_ONE   = 3'd0,
        ODD_THREE = 3'd1,
        ODD_FIVE  = 3'd2,
        ODD_SEVEN = 3'd3,
        ODD_NINE  = 3'd4
    } odd_code_e;
endpackage

// File: rtl/vtx_pad_msb_find.sv
// Module: priority encoder returning the position of the highest set bit.
// Assumes: a zero input reports position 0 with found low.
module vtx_pad_msb_find #(
    parameter int W       = vtx_pad_pkg::CNT_W,
    parameter int POS_W   = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             found
);
    // Scan upward so the highest set bit is the last one to write pos.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = POS_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtx_pad_small_map.sv
// Module: padding for counts below SMALL_LIM by exhaustive candidate search.
// Picks the smallest (2o+1)*2^s with s >= MIN_SHIFT that is greater than the
// count. Assumes cnt < SMALL_LIM; SMALL_LIM itself is always a candidate.
module vtx_pad_small_map
    import vtx_pad_pkg::*;
#(
    parameter int LIM = SMALL_LIM
) (
    input  logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   padded,
    output logic [SHIFT_W-1:0] shift,
    output logic [ODD_W-1:0]   odd
);
    localparam int TOP_SHIFT = $clog2(LIM);

    // Walk every odd factor and exponent, keep the smallest qualifying value.
    always_comb begin
        int best;
        best   = LIM;
        shift  = SHIFT_W'(TOP_SHIFT);
        odd    = ODD_ONE;
        for (int o = 0; o <= 4; o++) begin
            for (int s = MIN_SHIFT; s <= TOP_SHIFT; s++) begin
                int v;
                v = (2 * o + 1) << s;
                if (v <= LIM && CNT_W'(v) > cnt && v < best) begin
                    best  = v;
                    shift = SHIFT_W'(s);
                    odd   = ODD_W'(o);
                end
            end
        end
        padded = CNT_W'(best);
    end
endmodule

// File: rtl/vtx_pad_large_map.sv
// Module: leading-bit padding for counts of SMALL_LIM and above.
// Assumes the leading-one position pos is at least 3 (guaranteed when
// cnt >= SMALL_LIM). Produces the product in WIDE_W bits and flags when it
// does not fit in CNT_W bits.
module vtx_pad_large_map
    import vtx_pad_pkg::*;
(
    input  logic [CNT_W-1:0]   cnt,
    input  logic [SHIFT_W-1:0] pos,
    output logic [CNT_W-1:0]   padded,
    output logic [SHIFT_W-1:0] shift,
    output logic [ODD_W-1:0]   odd,
    output logic               ovf
);
    logic [SHIFT_W-1:0] n_low;
    logic [3:0]         lead4;
    logic [WIDE_W-1:0]  wide;

    // Exponent of the bits below the leading four, and the leading four bits.
    always_comb begin
        n_low = pos - SHIFT_W'(3);
        lead4 = 4'(cnt >> n_low);
    end

    // Map the leading pattern to an odd factor and exponent.
    always_comb begin
        unique casez (lead4)
            4'b1000: begin odd = ODD_NINE;  shift = n_low;               end
            4'b1001: begin odd = ODD_FIVE;  shift = n_low + SHIFT_W'(1); end
            4'b101?: begin odd = ODD_THREE; shift = n_low + SHIFT_W'(2); end
            4'b110?: begin odd = ODD_SEVEN; shift = n_low + SHIFT_W'(1); end
            default: begin odd = ODD_ONE;   shift = n_low + SHIFT_W'(4); end
        endcase
    end

    // Build the padded value wide, then split into result and overflow.
    always_comb begin
        wide   = WIDE_W'({odd, 1'b1}) << shift;
        padded = wide[CNT_W-1:0];
        ovf    = |wide[WIDE_W-1:CNT_W];
    end
endmodule

// File: rtl/vtx_pad_gen.sv
// Module: padded vertex count generator, one registered stage.
// Chooses the small-count search below SMALL_LIM and the leading-bit rule
// otherwise; registers the result when in_valid is high and holds it
// otherwise. Synchronous active-low reset.
module vtx_pad_gen
    import vtx_pad_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CNT_W-1:0]   in_count,
    output logic               out_valid,
    output logic [CNT_W-1:0]   out_padded,
    output logic [SHIFT_W-1:0] out_shift,
    output logic [ODD_W-1:0]   out_odd,
    output logic               out_overflow
);
    logic [SHIFT_W-1:0] lead_pos;
    logic               lead_found;
    logic [CNT_W-1:0]   sm_padded, lg_padded, nx_padded;
    logic [SHIFT_W-1:0] sm_shift,  lg_shift,  nx_shift;
    logic [ODD_W-1:0]   sm_odd,    lg_odd,    nx_odd;
    logic               lg_ovf,    nx_ovf;
    logic               is_small;

    vtx_pad_msb_find #(.W(CNT_W), .POS_W(SHIFT_W)) u_msb (
        .vec   (in_count),
        .pos   (lead_pos),
        .found (lead_found)
    );

    vtx_pad_small_map #(.LIM(SMALL_LIM)) u_small (
        .cnt    (in_count),
        .padded (sm_padded),
        .shift  (sm_shift),
        .odd    (sm_odd)
    );

    vtx_pad_large_map u_large (
        .cnt    (in_count),
        .pos    (lead_pos),
        .padded (lg_padded),
        .shift  (lg_shift),
        .odd    (lg_odd),
        .ovf    (lg_ovf)
    );

    // Select the path: small search below the limit or with no bit set.
    always_comb begin
        is_small = (in_count < CNT_W'(SMALL_LIM)) || !lead_found;
        if (is_small) begin
            nx_padded = sm_padded;
            nx_shift  = sm_shift;
            nx_odd    = sm_odd;
            nx_ovf    = 1'b0;
        end else begin
            nx_padded = lg_padded;
            nx_shift  = lg_shift;
            nx_odd    = lg_odd;
            nx_ovf    = lg_ovf;
        end
    end

    // Output stage: valid follows the request, data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_padded   <= '0;
            out_shift    <= '0;
            out_odd      <= '0;
            out_overflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_padded   <= nx_padded;
                out_shift    <= nx_shift;
                out_odd      <= nx_odd;
                out_overflow <= nx_ovf;
            end
        end
    end
endmodule

// File: rtl/vtx_pad_gen_chk.sv
// Checker: temporal properties of vtx_pad_gen, attached with bind below.
// Assumes it sees the top module's ports only.
module vtx_pad_gen_chk
    import vtx_pad_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [CNT_W-1:0]   in_count,
    input logic               out_valid,
    input logic [CNT_W-1:0]   out_padded,
    input logic [SHIFT_W-1:0] out_shift,
    input logic [ODD_W-1:0]   out_odd,
    input logic               out_overflow
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_data_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_padded) && $stable(out_shift)
                       && $stable(out_odd) && $stable(out_overflow)));

    assert_strictly_larger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_overflow) |-> (out_padded > $past(in_count)));

    assert_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_overflow) |->
            (out_padded[1:0] == 2'b00 && out_odd <= 3'd4 &&
             WIDE_W'(out_padded) == (WIDE_W'({out_odd, 1'b1}) << out_shift)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_overflow == ($past(in_count) >= 32'hE000_0000)));

    assert_overflow_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |->
            (out_padded == '0 && out_odd == '0 && out_shift == SHIFT_W'(CNT_W)));
endmodule

bind vtx_pad_gen vtx_pad_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_count     (in_count),
    .out_valid    (out_valid),
    .out_padded   (out_padded),
    .out_shift    (out_shift),
    .out_odd      (out_odd),
    .out_overflow (out_overflow)
);

// File: tb/vtx_pad_gen_test.sv
// Bench: vector table walked by one loop, then directed reset/hold tests.
module vtx_pad_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_count;
    logic        out_valid;
    logic [31:0] out_padded;
    logic [5:0]  out_shift;
    logic [2:0]  out_odd;
    logic        out_overflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vtx_pad_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
        .out_valid(out_valid), .out_padded(out_padded), .out_shift(out_shift),
        .out_odd(out_odd), .out_overflow(out_overflow)
    );

    // {count, padded, shift, odd, overflow}
    localparam int NV = 30;
    localparam logic [73:0] VEC [NV] = '{
        {32'd0,          32'd4,          6'd2,  3'd0, 1'b0},
        {32'd1,          32'd4,          6'd2,  3'd0, 1'b0},
        {32'd2,          32'd4,          6'd2,  3'd0, 1'b0},
        {32'd3,          32'd4,          6'd2,  3'd0, 1'b0},
        {32'd4,          32'd8,          6'd3,  3'd0, 1'b0},
        {32'd7,          32'd8,          6'd3,  3'd0, 1'b0},
        {32'd8,          32'd12,         6'd2,  3'd1, 1'b0},
        {32'd11,         32'd12,         6'd2,  3'd1, 1'b0},
        {32'd12,         32'd16,         6'd4,  3'd0, 1'b0},
        {32'd16,         32'd20,         6'd2,  3'd2, 1'b0},
        {32'd19,         32'd20,         6'd2,  3'd2, 1'b0},
        {32'd20,         32'd24,         6'd3,  3'd1, 1'b0},
        {32'd27,         32'd28,         6'd2,  3'd3, 1'b0},
        {32'd32,         32'd36,         6'd2,  3'd4, 1'b0},
        {32'd40,         32'd48,         6'd4,  3'd1, 1'b0},
        {32'd63,         32'd64,         6'd6,  3'd0, 1'b0},
        {32'd64,         32'd72,         6'd3,  3'd4, 1'b0},
        {32'd70,         32'd72,         6'd3,  3'd4, 1'b0},
        {32'd72,         32'd80,         6'd4,  3'd2, 1'b0},
        {32'd80,         32'd96,         6'd5,  3'd1, 1'b0},
        {32'd100,        32'd112,        6'd4,  3'd3, 1'b0},
        {32'd120,        32'd128,        6'd7,  3'd0, 1'b0},
        {32'd1000,       32'd1024,       6'd10, 3'd0, 1'b0},
        {32'd1024,       32'd1152,       6'd7,  3'd4, 1'b0},
        {32'h0000_9000,  32'h0000_A000,  6'd13, 3'd2, 1'b0},
        {32'h0000_FFFF,  32'h0001_0000,  6'd16, 3'd0, 1'b0},
        {32'h8000_0000,  32'h9000_0000,  6'd28, 3'd4, 1'b0},
        {32'hDFFF_FFFF,  32'hE000_0000,  6'd29, 3'd3, 1'b0},
        {32'hE000_0000,  32'h0000_0000,  6'd32, 3'd0, 1'b1},
        {32'hFFFF_FFFF,  32'h0000_0000,  6'd32, 3'd0, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [31:0] c, input logic ov);
        if (ov)            return "R6";
        else if (c == 70)  return "R7";
        else if (c < 64)   return "R5";
        else               return "R4";
    endfunction

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_count = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "out_valid after reset",   64'(out_valid),    64'd0);
        check("R8", "out_padded after reset",  64'(out_padded),   64'd0);
        check("R8", "out_shift after reset",   64'(out_shift),    64'd0);
        check("R8", "out_odd after reset",     64'(out_odd),      64'd0);
        check("R8", "out_overflow after reset",64'(out_overflow), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk, back to back: each result lands one edge later.
        for (int i = 0; i < NV; i++) begin
            logic [31:0] c, p;
            logic [5:0]  s;
            logic [2:0]  o;
            logic        v;
            string       t;
            {c, p, s, o, v} = VEC[i];
            t = tag_for(c, v);
            in_valid = 1'b1;
            in_count = c;
            @(negedge clk);
            check("R1", "out_valid", 64'(out_valid), 64'd1);
            check(t, $sformatf("padded for %0d", c),  64'(out_padded),   64'(p));
            check(t, $sformatf("shift for %0d", c),   64'(out_shift),    64'(s));
            check(t, $sformatf("odd for %0d", c),     64'(out_odd),      64'(o));
            check(t, $sformatf("overflow for %0d", c),64'(out_overflow), 64'(v));
            if (!v) begin
                check("R2", $sformatf("padded > %0d", c), 64'(out_padded > c), 64'd1);
                check("R3", $sformatf("multiple of 4 for %0d", c),
                      64'(out_padded[1:0]), 64'd0);
            end
        end

        // R1: idle cycle drops valid and holds data (last result: overflow case)
        in_valid = 1'b0;
        in_count = 32'd5;
        @(negedge clk);
        check("R1", "valid low when idle", 64'(out_valid),    64'd0);
        check("R1", "padded held",         64'(out_padded),   64'd0);
        check("R1", "shift held",          64'(out_shift),    64'd32);
        check("R1", "overflow held",       64'(out_overflow), 64'd1);

        // R7 once more after idle, then hold check on a non-zero value
        in_valid = 1'b1;
        in_count = 32'd70;
        @(negedge clk);
        check("R7", "padded for 70", 64'(out_padded), 64'd72);
        check("R7", "odd for 70",    64'(out_odd),    64'd4);
        check("R7", "shift for 70",  64'(out_shift),  64'd3);
        in_valid = 1'b0;
        in_count = 32'd1000;
        repeat (2) @(negedge clk);
        check("R1", "padded held across idle", 64'(out_padded), 64'd72);

        // R8: reset in the middle of a request stream
        in_valid = 1'b1;
        in_count = 32'd120;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R8", "valid cleared by reset",  64'(out_valid),  64'd0);
        check("R8", "padded cleared by reset", 64'(out_padded), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4", "padded for 120 after reset", 64'(out_padded), 64'd128);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule